// File: doc/BRIEF.md
# Four-Channel 12-Bit DAC Double-Rank Register Front End

This block is a clock-synchronous model of the digital side of a four-channel, 12-bit converter. Each channel keeps an input rank, which the bus writes, and an output rank, whose value drives the converter. A set of active-low strobes is decoded on every rising clock edge. Two are chip select and read. A transfer strobe copies input ranks to output ranks. A latch strobe picks the transparent variant, and a mode strobe steers access to a per-channel mode word. The strobes also carry three active-low nibble (quad) enables and a 2-bit channel address.

From these strobes the block supports several operations. A plain load writes one channel's input rank. Loading with transfer asserted gives a transparent update, either broadcast to all channels or limited to the addressed one. Holding transfer low permanently makes every load appear at the outputs. The stored codes and the mode word can both be read back. The bus is split into a write data input, a registered read data output and an output enable. A parameter fixes the bus access width to nibble, byte or full word. The nibble enables then say which parts of the 12-bit register a transfer touches.

Top module: `quad_dac_regs`

## Requirements
- R1: Asynchronous reset (rst_ni low) clears every input rank, every output rank, the 8-bit mode word, the read data and the output enable to zero.
- R2: A load (chip select low, read high, mode strobe high) writes only the input rank of the channel on chan_i. Output ranks do not change unless transfer is also low.
- R3: When transfer is low on an edge, every output rank takes its channel's input rank value, including any write on that same edge. Transfer acts whatever the state of chip select. While transfer is high, code_o does not change.
- R4: Fully transparent update: a load with all three nibble enables low, transfer low and latch high writes the data into both ranks of all four channels on that edge.
- R5: Partially transparent update: the same condition with latch low writes the data into both ranks of the addressed channel only. The other channels' output ranks take their own input ranks.
- R6: With transfer held low over a run of cycles, every load is visible on code_o one cycle after its edge, in both transparent variants.
- R7: Code readback (chip select low, read low, mode strobe high) puts the addressed channel's input rank on rdata_o, with rdata_oe_o high, in the cycle after the strobe edge.
- R8: A mode write (chip select low, read high, mode strobe low) updates mode bits 7:0 through nibble enables 0 and 1. Mode readback requires chip select, read, mode strobe and nibble enables 0 and 1 low with transfer high. It returns the mode word zero-extended to 12 bits.
- R9: Nibble enable k (active low) covers code bits 4k+3:4k. On a write, disabled nibbles keep their value. On a readback, disabled nibbles read as zero.
- R10: Data lanes depend on ACCESS (0 nibble, 1 byte, 2 word). Register nibble k uses bus nibble k mod L, where L is 1, 2 or 3. This holds for writes. On readback, the enabled nibbles are ORed into bus nibble k mod L.
- R11: rdata_oe_o goes high only in the cycle after a readback strobe, and rdata_o is zero whenever rdata_oe_o is low. With chip select high, no rank or mode bit is written and no readback starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| chip_sel_ni | input | 1 | Chip select, active low |
| read_ni | input | 1 | Read strobe, active low |
| xfer_ni | input | 1 | Input-to-output rank transfer, active low |
| latch_ni | input | 1 | Low selects single-channel transparency |
| mode_ni | input | 1 | Mode word access, active low |
| quad_ni | input | 3 | Nibble enables, active low, bit k for code bits 4k+3:4k |
| chan_i | input | 2 | Channel address |
| wdata_i | input | 12 | Write data bus |
| rdata_o | output | 12 | Registered readback data |
| rdata_oe_o | output | 1 | Readback data valid / bus drive enable |
| code_o | output | 48 | Output-rank codes, channel n at bits 12n+11:12n |

## Verification
Some properties are checked by assertions on every cycle. Output ranks must hold whenever transfer is high. The output enable must follow each kind of readback strobe and never appear without one. Read data must be zero while the enable is low. In the full-word variant, both transparent updates must land the written word on the expected output ranks. Nibble masking, lane folding for the narrower access widths, mode-word contents, reset contents and long runs with transfer held low are covered only by the bench. The bench drives three instances (nibble, byte, word) in parallel through directed scenarios and a long pseudo-random strobe sweep, and compares each against an arithmetic model.

// File: rtl/quad_dac_pkg.sv
package quad_dac_pkg;

  typedef enum logic [1:0] {
    ACC_NIB  = 2'd0,
    ACC_BYTE = 2'd1,
    ACC_WORD = 2'd2
  } acc_e;

  typedef struct packed {
    logic load;
    logic bcast;
    logic xfer;
    logic mode_wr;
    logic rd_code;
    logic rd_mode;
  } strobe_t;

  // bus nibbles used per access width
  function automatic int lanes_per(acc_e a, int nib_n);
    case (a)
      ACC_NIB:  return 1;
      ACC_BYTE: return 2;
      default:  return nib_n;
    endcase
  endfunction

endpackage

// File: rtl/qdac_decode.sv
module qdac_decode
  import quad_dac_pkg::*;
#(
  parameter int NIB_N = 3
) (
  input  logic             chip_sel_ni,
  input  logic             read_ni,
  input  logic             xfer_ni,
  input  logic             latch_ni,
  input  logic             mode_ni,
  input  logic [NIB_N-1:0] quad_ni,
  output strobe_t          stb_o
);

  logic sel, wr, all_quads;

  always_comb begin
    sel       = ~chip_sel_ni;
    wr        = sel & read_ni & mode_ni;
    all_quads = ~|quad_ni;
    stb_o.load    = wr;
    stb_o.bcast   = wr & all_quads & latch_ni & ~xfer_ni;
    stb_o.xfer    = ~xfer_ni;
    stb_o.mode_wr = sel & read_ni & ~mode_ni;
    stb_o.rd_code = sel & ~read_ni & mode_ni;
    stb_o.rd_mode = sel & ~read_ni & ~mode_ni & ~quad_ni[0] & ~quad_ni[1] & xfer_ni;
  end

endmodule

// File: rtl/qdac_channel.sv
module qdac_channel #(
  parameter int CODE_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [CODE_W-1:0] mask_i,
  input  logic [CODE_W-1:0] data_i,
  input  logic              xfer_i,
  output logic [CODE_W-1:0] in_q_o,
  output logic [CODE_W-1:0] out_q_o
);

  logic [CODE_W-1:0] in_d, out_d;

  always_comb begin
    in_d  = wr_en_i ? ((in_q_o & ~mask_i) | (data_i & mask_i)) : in_q_o;
    // transfer sees same-edge write: gives transparency
    out_d = xfer_i ? in_d : out_q_o;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_q_o  <= '0;
      out_q_o <= '0;
    end else begin
      in_q_o  <= in_d;
      out_q_o <= out_d;
    end
  end

endmodule

// File: rtl/qdac_readback.sv
module qdac_readback
  import quad_dac_pkg::*;
#(
  parameter int   N_CH   = 4,
  parameter int   CODE_W = 12,
  parameter acc_e ACCESS = ACC_WORD,
  localparam int  NIB_N  = CODE_W / 4,
  localparam int  CHAN_W = $clog2(N_CH),
  localparam int  PER    = lanes_per(ACCESS, NIB_N)
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         rd_code_i,
  input  logic                         rd_mode_i,
  input  logic [CHAN_W-1:0]            chan_i,
  input  logic [CODE_W-1:0]            mask_i,
  input  logic [N_CH-1:0][CODE_W-1:0]  ranks_i,
  input  logic [CODE_W-1:0]            mode_i,
  output logic [CODE_W-1:0]            rdata_o,
  output logic                         oe_o
);

  logic [CODE_W-1:0] src, masked, folded;
  logic              rd_any;

  always_comb begin
    rd_any = rd_code_i | rd_mode_i;
    src    = rd_mode_i ? mode_i : ranks_i[chan_i];
    masked = src & mask_i;
    folded = '0;
    for (int k = 0; k < NIB_N; k++) begin
      folded[(k % PER)*4 +: 4] = folded[(k % PER)*4 +: 4] | masked[k*4 +: 4];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      oe_o    <= 1'b0;
      rdata_o <= '0;
    end else begin
      oe_o    <= rd_any;
      rdata_o <= rd_any ? folded : '0;
    end
  end

endmodule

// File: rtl/quad_dac_regs.sv
module quad_dac_regs
  import quad_dac_pkg::*;
#(
  parameter int   N_CH   = 4,
  parameter int   CODE_W = 12,
  parameter int   MODE_W = 8,
  parameter acc_e ACCESS = ACC_WORD
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     chip_sel_ni,
  input  logic                     read_ni,
  input  logic                     xfer_ni,
  input  logic                     latch_ni,
  input  logic                     mode_ni,
  input  logic [CODE_W/4-1:0]      quad_ni,
  input  logic [$clog2(N_CH)-1:0]  chan_i,
  input  logic [CODE_W-1:0]        wdata_i,
  output logic [CODE_W-1:0]        rdata_o,
  output logic                     rdata_oe_o,
  output logic [N_CH*CODE_W-1:0]   code_o
);

  localparam int NIB_N  = CODE_W / 4;
  localparam int CHAN_W = $clog2(N_CH);
  localparam int PER    = lanes_per(ACCESS, NIB_N);

  strobe_t                    stb;
  logic [CODE_W-1:0]          nib_mask, lane;
  logic [N_CH-1:0][CODE_W-1:0] in_rank, out_rank;
  logic [MODE_W-1:0]          mode_q;

  qdac_decode #(.NIB_N(NIB_N)) u_decode (
    .chip_sel_ni (chip_sel_ni),
    .read_ni     (read_ni),
    .xfer_ni     (xfer_ni),
    .latch_ni    (latch_ni),
    .mode_ni     (mode_ni),
    .quad_ni     (quad_ni),
    .stb_o       (stb)
  );

  for (genvar k = 0; k < NIB_N; k++) begin : g_lane
    assign nib_mask[k*4 +: 4] = {4{~quad_ni[k]}};
    assign lane[k*4 +: 4]     = wdata_i[(k % PER)*4 +: 4];
  end

  for (genvar ch = 0; ch < N_CH; ch++) begin : g_chan
    qdac_channel #(.CODE_W(CODE_W)) u_chan (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .wr_en_i (stb.load & (stb.bcast | (chan_i == CHAN_W'(ch)))),
      .mask_i  (nib_mask),
      .data_i  (lane),
      .xfer_i  (stb.xfer),
      .in_q_o  (in_rank[ch]),
      .out_q_o (out_rank[ch])
    );
    assign code_o[ch*CODE_W +: CODE_W] = out_rank[ch];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= '0;
    end else if (stb.mode_wr) begin
      mode_q <= (mode_q & ~nib_mask[MODE_W-1:0]) | (lane[MODE_W-1:0] & nib_mask[MODE_W-1:0]);
    end
  end

  qdac_readback #(
    .N_CH   (N_CH),
    .CODE_W (CODE_W),
    .ACCESS (ACCESS)
  ) u_readback (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rd_code_i (stb.rd_code),
    .rd_mode_i (stb.rd_mode),
    .chan_i    (chan_i),
    .mask_i    (nib_mask),
    .ranks_i   (in_rank),
    .mode_i    ({{(CODE_W-MODE_W){1'b0}}, mode_q}),
    .rdata_o   (rdata_o),
    .oe_o      (rdata_oe_o)
  );

endmodule

// File: rtl/quad_dac_regs_checker.sv
module quad_dac_regs_checker
  import quad_dac_pkg::*;
#(
  parameter int   N_CH   = 4,
  parameter int   CODE_W = 12,
  parameter acc_e ACCESS = ACC_WORD
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic                     chip_sel_ni,
  input logic                     read_ni,
  input logic                     xfer_ni,
  input logic                     latch_ni,
  input logic                     mode_ni,
  input logic [CODE_W/4-1:0]      quad_ni,
  input logic [$clog2(N_CH)-1:0]  chan_i,
  input logic [CODE_W-1:0]        wdata_i,
  input logic [CODE_W-1:0]        rdata_o,
  input logic                     rdata_oe_o,
  input logic [N_CH*CODE_W-1:0]   code_o
);

  logic [CODE_W-1:0]        code_arr [N_CH];
  logic [$clog2(N_CH)-1:0]  chan_q;
  logic                     wr_cond, full_cond, part_cond;

  for (genvar ch = 0; ch < N_CH; ch++) begin : g_arr
    assign code_arr[ch] = code_o[ch*CODE_W +: CODE_W];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chan_q <= '0;
    else         chan_q <= chan_i;
  end

  assign wr_cond   = !chip_sel_ni && read_ni && mode_ni && (quad_ni == '0) && !xfer_ni;
  assign full_cond = wr_cond && latch_ni;
  assign part_cond = wr_cond && !latch_ni;

  p_hold_no_xfer_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_ni |=> $stable(code_o));

  p_code_read_oe_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!chip_sel_ni && !read_ni && mode_ni) |=> rdata_oe_o);

  p_mode_read_oe_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!chip_sel_ni && !read_ni && !mode_ni && !quad_ni[0] && !quad_ni[1] && xfer_ni) |=> rdata_oe_o);

  p_oe_needs_read_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_oe_o |-> $past(!chip_sel_ni && !read_ni));

  p_idle_zero_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rdata_oe_o |-> (rdata_o == '0));

  if (ACCESS == ACC_WORD) begin : g_word
    p_full_transp_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      full_cond |=> (code_o == {N_CH{$past(wdata_i)}}));

    p_part_transp_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      part_cond |=> (code_arr[chan_q] == $past(wdata_i)));
  end

endmodule

bind quad_dac_regs quad_dac_regs_checker #(
  .N_CH   (N_CH),
  .CODE_W (CODE_W),
  .ACCESS (ACCESS)
) u_checker (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .chip_sel_ni (chip_sel_ni),
  .read_ni     (read_ni),
  .xfer_ni     (xfer_ni),
  .latch_ni    (latch_ni),
  .mode_ni     (mode_ni),
  .quad_ni     (quad_ni),
  .chan_i      (chan_i),
  .wdata_i     (wdata_i),
  .rdata_o     (rdata_o),
  .rdata_oe_o  (rdata_oe_o),
  .code_o      (code_o)
);

// File: tb/quad_dac_regs_bench.sv
module quad_dac_regs_bench;
  import quad_dac_pkg::*;

  localparam int N_ACC = 3;

  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic        chip_sel_ni, read_ni, xfer_ni, latch_ni, mode_ni;
  logic [2:0]  quad_ni;
  logic [1:0]  chan_i;
  logic [11:0] wdata_i;

  logic [11:0] rdata [N_ACC];
  logic        oe    [N_ACC];
  logic [47:0] code  [N_ACC];

  always #2 clk_i = ~clk_i;

  for (genvar a = 0; a < N_ACC; a++) begin : g_acc
    quad_dac_regs #(.ACCESS(acc_e'(a))) u_quad_dac_regs (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .chip_sel_ni (chip_sel_ni),
      .read_ni     (read_ni),
      .xfer_ni     (xfer_ni),
      .latch_ni    (latch_ni),
      .mode_ni     (mode_ni),
      .quad_ni     (quad_ni),
      .chan_i      (chan_i),
      .wdata_i     (wdata_i),
      .rdata_o     (rdata[a]),
      .rdata_oe_o  (oe[a]),
      .code_o      (code[a])
    );
  end

  // arithmetic model
  logic [11:0] m_in  [N_ACC][4];
  logic [11:0] m_out [N_ACC][4];
  logic [7:0]  m_mode[N_ACC];
  logic        e_oe  [N_ACC];
  logic [11:0] e_rd  [N_ACC];

  int n_chk  = 0;
  int n_fail = 0;

  task automatic chk(string tag, string what, logic [47:0] act, logic [47:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int a = 0; a < N_ACC; a++) begin
      for (int c = 0; c < 4; c++) begin
        m_in[a][c]  = '0;
        m_out[a][c] = '0;
      end
      m_mode[a] = '0;
      e_oe[a]   = 1'b0;
      e_rd[a]   = '0;
    end
  endtask

  task automatic model_step(logic cs, logic rd, logic tr, logic ls, logic ms,
                            logic [2:0] q, logic [1:0] ch, logic [11:0] d);
    for (int a = 0; a < N_ACC; a++) begin
      int per;
      logic [11:0] lane, mask, src, msk, fold;
      logic t, wr, bc, rc, rm;
      per = (a == 0) ? 1 : ((a == 1) ? 2 : 3);
      for (int k = 0; k < 3; k++) begin
        lane[k*4 +: 4] = d[(k % per)*4 +: 4];
        mask[k*4 +: 4] = {4{~q[k]}};
      end
      t  = !tr;
      wr = !cs && rd && ms;
      bc = wr && (q == 3'b000) && ls && t;
      rc = !cs && !rd && ms;
      rm = !cs && !rd && !ms && !q[0] && !q[1] && tr;
      src  = rm ? {4'b0, m_mode[a]} : m_in[a][ch];
      msk  = src & mask;
      fold = '0;
      for (int k = 0; k < 3; k++) fold[(k % per)*4 +: 4] = fold[(k % per)*4 +: 4] | msk[k*4 +: 4];
      e_oe[a] = rc || rm;
      e_rd[a] = (rc || rm) ? fold : '0;
      if (!cs && rd && !ms) m_mode[a] = (m_mode[a] & ~mask[7:0]) | (lane[7:0] & mask[7:0]);
      for (int c = 0; c < 4; c++)
        if (wr && (bc || c == int'(ch))) m_in[a][c] = (m_in[a][c] & ~mask) | (lane & mask);
      if (t) for (int c = 0; c < 4; c++) m_out[a][c] = m_in[a][c];
    end
  endtask

  task automatic compare(string tag);
    for (int a = 0; a < N_ACC; a++) begin
      chk(tag, $sformatf("acc%0d code", a), code[a],
          {m_out[a][3], m_out[a][2], m_out[a][1], m_out[a][0]});
      chk(tag, $sformatf("acc%0d oe", a), {47'b0, oe[a]}, {47'b0, e_oe[a]});
      chk(tag, $sformatf("acc%0d rdata", a), {36'b0, rdata[a]}, {36'b0, e_rd[a]});
    end
  endtask

  task automatic cyc(logic cs, logic rd, logic tr, logic ls, logic ms,
                     logic [2:0] q, logic [1:0] ch, logic [11:0] d, string tag);
    chip_sel_ni = cs; read_ni = rd; xfer_ni = tr; latch_ni = ls; mode_ni = ms;
    quad_ni = q; chan_i = ch; wdata_i = d;
    @(posedge clk_i);
    model_step(cs, rd, tr, ls, ms, q, ch, d);
    @(negedge clk_i);
    compare(tag);
  endtask

  task automatic idle(string tag);
    cyc(1, 1, 1, 1, 1, 3'b111, 2'd0, 12'h000, tag);
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    model_reset();
    @(negedge clk_i);
    compare("R1 reset");
    @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  initial begin : watchdog
    #(4 * 150000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk + 1);
    $finish;
  end

  initial begin : main
    logic [31:0] x;
    rst_ni = 1'b0;
    chip_sel_ni = 1; read_ni = 1; xfer_ni = 1; latch_ni = 1; mode_ni = 1;
    quad_ni = 3'b111; chan_i = 0; wdata_i = 0;
    model_reset();
    @(negedge clk_i);
    compare("R1 reset");
    rst_ni = 1'b1;
    idle("R1 idle");

    // R2 plain loads, outputs untouched
    for (int c = 0; c < 4; c++) cyc(0, 1, 1, 1, 1, 3'b000, 2'(c), 12'h3A1 + 12'(c * 12'h111), "R2 load");
    // R7 readback of every channel
    for (int c = 0; c < 4; c++) cyc(0, 0, 1, 1, 1, 3'b000, 2'(c), 12'h000, "R7 read");
    idle("R11 idle after read");
    // R3 transfer with chip select high
    cyc(1, 1, 0, 1, 1, 3'b111, 2'd0, 12'h000, "R3 xfer");
    idle("R3 hold");

    // R9 R10 nibble enable and lane sweep
    for (int q = 0; q < 8; q++) begin
      cyc(0, 1, 1, 1, 1, 3'(q), 2'd1, 12'h7E5 ^ 12'(q * 12'h123), "R9 R10 masked write");
      for (int rq = 0; rq < 8; rq++) cyc(0, 0, 1, 1, 1, 3'(rq), 2'd1, 12'h000, "R9 R10 masked read");
    end

    // R4 fully transparent
    cyc(0, 1, 0, 1, 1, 3'b000, 2'd2, 12'h5A3, "R4 full");
    for (int c = 0; c < 4; c++) cyc(0, 0, 1, 1, 1, 3'b000, 2'(c), 12'h000, "R4 read");

    // R5 partially transparent
    for (int c = 0; c < 4; c++) cyc(0, 1, 1, 1, 1, 3'b000, 2'(c), 12'h0F0 | 12'(c), "R5 preload");
    for (int c = 0; c < 4; c++) cyc(0, 1, 0, 0, 1, 3'b000, 2'(c), 12'hC00 | 12'(c * 7), "R5 partial");

    // R6 transfer held low
    for (int i = 0; i < 24; i++)
      cyc(0, 1, 0, 1'(i % 2), 1, 3'((i % 3 == 0) ? 0 : i % 8), 2'(i % 4), 12'(i * 12'h1D7 + 3), "R6 xfer low");

    // R8 mode word
    for (int q = 0; q < 8; q++) begin
      cyc(0, 1, 1, 1, 0, 3'(q), 2'd0, 12'h9C6 ^ 12'(q * 12'h311), "R8 mode write");
      cyc(0, 0, 1, 1, 0, 3'b100, 2'd0, 12'h000, "R8 mode read");
      cyc(0, 0, 1, 1, 0, 3'b000, 2'd3, 12'h000, "R8 mode read all");
      cyc(0, 0, 0, 1, 0, 3'b000, 2'd0, 12'h000, "R8 mode read xfer low");
      cyc(0, 0, 1, 1, 0, 3'b101, 2'd0, 12'h000, "R8 mode read quad0 high");
    end

    // R11 chip select high ignores everything else
    cyc(1, 1, 1, 1, 1, 3'b000, 2'd0, 12'hFFF, "R11 cs high write");
    cyc(1, 1, 1, 1, 0, 3'b000, 2'd0, 12'hFFF, "R11 cs high mode write");
    cyc(1, 0, 1, 1, 1, 3'b000, 2'd0, 12'h000, "R11 cs high read");
    for (int c = 0; c < 4; c++) cyc(0, 0, 1, 1, 1, 3'b000, 2'(c), 12'h000, "R11 readback");
    cyc(0, 0, 1, 1, 0, 3'b000, 2'd0, 12'h000, "R11 mode readback");

    // pseudo-random sweep
    x = 32'h1BAD_5EED;
    for (int i = 0; i < 4000; i++) begin
      x = x ^ (x << 13);
      x = x ^ (x >> 17);
      x = x ^ (x << 5);
      cyc(x[0] & x[1], x[2], x[3] | x[4], x[5], x[6] | x[7], x[10:8], x[12:11], x[24:13],
          "R2 R3 R5 R7 R8 R9 sweep");
    end

    // R1 reset mid-run
    do_reset();
    for (int c = 0; c < 4; c++) cyc(0, 0, 1, 1, 1, 3'b000, 2'(c), 12'h000, "R1 read after reset");
    cyc(0, 0, 1, 1, 0, 3'b000, 2'd0, 12'h000, "R1 mode after reset");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule